// File: doc/BRIEF.md
# TDM Cascade Node for Chained Four-Channel Converters

This block is one stage in a chain of four-channel audio converters that share a single time-division-multiplexed serial line toward a host. Every stage sees the same system clock, the same bit-clock enable and the same frame-sync pulse. A frame is a run of 16-bit slots, four per stage, sent MSB first. The stage nearest the host drives the host's data input. Each other stage drives the serial input of the stage one step nearer the host.

At the start of a frame a stage captures its four parallel samples and sends them as the first four-slot group. While it does so, it stores the group arriving on its serial input from the stage behind it. In every later group it sends what it stored during the group before. It therefore emits its own group followed by its serial input delayed by one group, which is 64 bit times. When several stages are wired this way, the host receives the groups in chain order: stage 0 first, then stage 1, then the stages further away. The farthest stage has no neighbour behind it, so its relayed bits are zero whatever appears on its input. A parameter sets the chain depth and therefore the frame length.

Top module: `tdm_cascade_node`

## Requirements
- R1: On a cycle with `bit_en` high and `frame_sync` high, frame bit 0 is registered onto `chain_out`. This bit is the MSB of slot 0. Frame bits 0 to 63 carry the stage's four slots in slot order, each MSB first. Slot k comes from `local_samples[63-16k -: 16]`, so slot 0 is the top 16 bits.
- R2: The four local slots are captured on the frame-sync edge. A later change on `local_samples` has no effect on frame bits 1 to 63 of the current frame.
- R3: For frame bit p from 64 to 4*16*CHAIN_DEPTH-1, `chain_out` equals the value `chain_in` carried during frame bit p-64.
- R4: When CHAIN_DEPTH stages are chained, the host stream holds 4*CHAIN_DEPTH slots in the order stage 0 slots 0-3, stage 1 slots 0-3, and so on to the farthest stage.
- R5: In the stage whose NODE_INDEX equals CHAIN_DEPTH-1, `chain_in` is ignored and every relayed bit (frame bits 64 and later) is 0.
- R6: Once the last frame bit has been sent and no new frame sync arrives, `chain_out` is 0 on every following bit. Before the first frame sync after reset it is also 0.
- R7: `chain_out` changes only on cycles where `bit_en` is high. A `frame_sync` pulse without `bit_en` has no effect.
- R8: A frame sync that arrives in the middle of a frame restarts the frame at bit 0 with newly captured samples.
- R9: While `rst` is high, `chain_out` is driven to 0 and the stage is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Bit-clock enable, one cycle per serial bit |
| frame_sync | input | 1 | Frame start marker, sampled on `bit_en` cycles |
| local_samples | input | 4*SLOT_W | Four local samples, slot 0 in the top bits |
| chain_in | input | 1 | Serial data from the next stage away from the host |
| chain_out | output | 1 | Serial data toward the host or the next stage nearer it |

## Verification
The bench chains four stages, gives each different sample patterns, and checks that the stream at stage 0 carries all sixteen slots in chain order. An off-by-one in the group store would shift every relayed slot by one bit, and a wrong group order would put stage data into the wrong slots. Samples are scrambled right after frame sync, so a stage that reads its inputs live instead of capturing them would send corrupted slots. The farthest stage has its input held at 1, which exposes a terminal stage that relays it. Further tests restart a frame part-way through, idle past the end of a frame, and pulse frame sync without a bit enable. These catch stale frame positions, leftover data at the end of a frame, and output changes between enables.

// File: rtl/tdm_cascade_pkg.sv
package tdm_cascade_pkg;

  // Source selected for the next serial bit.
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_OWN   = 2'd1,
    PH_RELAY = 2'd2
  } tdm_phase_t;

  function automatic int unsigned group_bits(input int unsigned slot_w,
                                             input int unsigned slots);
    return slot_w * slots;
  endfunction

  function automatic int unsigned frame_bits(input int unsigned slot_w,
                                             input int unsigned slots,
                                             input int unsigned depth);
    return slot_w * slots * depth;
  endfunction

endpackage

// File: rtl/tdm_frame_timer.sv
module tdm_frame_timer
  import tdm_cascade_pkg::*;
#(
  parameter int unsigned FRAME_BITS = 256,
  parameter int unsigned GROUP_BITS = 64,
  localparam int unsigned PW = $clog2(FRAME_BITS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bit_en,
  input  logic          frame_sync,
  output tdm_phase_t    phase_nxt,
  output logic          frame_active,
  output logic [PW-1:0] bit_pos
);

  localparam logic [PW:0] GRP_L = (PW+1)'(GROUP_BITS);
  localparam logic [PW:0] FRM_L = (PW+1)'(FRAME_BITS);

  logic [PW:0] pos_p1;

  assign pos_p1 = {1'b0, bit_pos} + 1'b1;

  // Source of the bit that the next enable edge places on the line.
  always_comb begin
    if (frame_sync)           phase_nxt = PH_OWN;
    else if (!frame_active)   phase_nxt = PH_IDLE;
    else if (pos_p1 < GRP_L)  phase_nxt = PH_OWN;
    else if (pos_p1 < FRM_L)  phase_nxt = PH_RELAY;
    else                      phase_nxt = PH_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_pos      <= '0;
      frame_active <= 1'b0;
    end else if (bit_en) begin
      if (frame_sync) begin
        bit_pos      <= '0;
        frame_active <= 1'b1;
      end else if (frame_active) begin
        if (pos_p1 >= FRM_L) frame_active <= 1'b0;
        else                 bit_pos      <= pos_p1[PW-1:0];
      end
    end
  end

  // R8: a frame sync always restarts the position at bit 0
  p_restart_r8: assert property (@(posedge clk) disable iff (rst)
    (bit_en && frame_sync) |=> (bit_pos == '0 && frame_active));

  // R7: frame position holds between bit enables
  p_pos_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> ($stable(bit_pos) && $stable(frame_active)));

endmodule

// File: rtl/tdm_local_shifter.sv
module tdm_local_shifter #(
  parameter int unsigned WIDTH = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_en,
  input  logic             frame_sync,
  input  logic [WIDTH-1:0] samples,
  output logic             own_bit
);

  logic [WIDTH-1:0] snap;

  // The frame's first bit goes straight from the port. The rest are
  // captured in the same edge so that all four slots come from one sample instant.
  assign own_bit = frame_sync ? samples[WIDTH-1] : snap[WIDTH-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      snap <= '0;
    end else if (bit_en) begin
      if (frame_sync) snap <= {samples[WIDTH-2:0], 1'b0};
      else            snap <= {snap[WIDTH-2:0], 1'b0};
    end
  end

endmodule

// File: rtl/tdm_group_delay.sv
module tdm_group_delay #(
  parameter int unsigned DEPTH = 63
) (
  input  logic clk,
  input  logic bit_en,
  input  logic din,
  output logic tap
);

  // Plain enabled shift line without reset. It suits shift-register
  // primitives and is always refilled before a frame reads it.
  logic [DEPTH-1:0] line;

  always_ff @(posedge clk) begin
    if (bit_en) line <= {line[DEPTH-2:0], din};
  end

  assign tap = line[DEPTH-1];

endmodule

// File: rtl/tdm_cascade_node.sv
module tdm_cascade_node
  import tdm_cascade_pkg::*;
#(
  parameter int unsigned SLOT_W         = 16,
  parameter int unsigned SLOTS_PER_NODE = 4,
  parameter int unsigned CHAIN_DEPTH    = 4,
  parameter int unsigned NODE_INDEX     = 0
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             bit_en,
  input  logic                             frame_sync,
  input  logic [SLOTS_PER_NODE*SLOT_W-1:0] local_samples,
  input  logic                             chain_in,
  output logic                             chain_out
);

  localparam int unsigned GROUP_BITS = group_bits(SLOT_W, SLOTS_PER_NODE);
  localparam int unsigned FRAME_BITS = frame_bits(SLOT_W, SLOTS_PER_NODE, CHAIN_DEPTH);
  localparam int unsigned PW         = $clog2(FRAME_BITS);
  localparam int unsigned LW         = SLOTS_PER_NODE * SLOT_W;
  localparam bit          TERMINAL   = (NODE_INDEX == CHAIN_DEPTH - 1);
  localparam logic [PW-1:0] RELAY_FROM = PW'(GROUP_BITS - 1);

  tdm_phase_t    phase_nxt;
  logic          frame_active;
  logic [PW-1:0] bit_pos;
  logic          own_bit;
  logic          relay_bit;

  tdm_frame_timer #(
    .FRAME_BITS (FRAME_BITS),
    .GROUP_BITS (GROUP_BITS)
  ) u_timer (
    .clk          (clk),
    .rst          (rst),
    .bit_en       (bit_en),
    .frame_sync   (frame_sync),
    .phase_nxt    (phase_nxt),
    .frame_active (frame_active),
    .bit_pos      (bit_pos)
  );

  tdm_local_shifter #(
    .WIDTH (LW)
  ) u_local (
    .clk        (clk),
    .rst        (rst),
    .bit_en     (bit_en),
    .frame_sync (frame_sync),
    .samples    (local_samples),
    .own_bit    (own_bit)
  );

  // Register output and tap together form one group of delay: the line
  // holds GROUP_BITS-1 bits and the output flop holds the last one.
  generate
    if (TERMINAL) begin : g_terminal
      assign relay_bit = 1'b0 & chain_in;
    end else begin : g_relay
      tdm_group_delay #(
        .DEPTH (GROUP_BITS - 1)
      ) u_delay (
        .clk    (clk),
        .bit_en (bit_en),
        .din    (chain_in),
        .tap    (relay_bit)
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_out <= 1'b0;
    end else if (bit_en) begin
      unique case (phase_nxt)
        PH_OWN:   chain_out <= own_bit;
        PH_RELAY: chain_out <= relay_bit;
        default:  chain_out <= 1'b0;
      endcase
    end
  end

  // R1: frame bit 0 is the MSB of slot 0 sampled at the sync edge
  p_first_bit_r1: assert property (@(posedge clk) disable iff (rst)
    (bit_en && frame_sync) |=> (chain_out == $past(local_samples[LW-1])));

  // R6: outside a frame the line stays low
  p_idle_low_r6: assert property (@(posedge clk) disable iff (rst)
    (bit_en && !frame_sync && !frame_active) |=> (chain_out == 1'b0));

  // R7: the line only moves on bit enables
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> $stable(chain_out));

  generate
    if (TERMINAL) begin : g_term_chk
      // R5: the farthest stage sends zeros in every relay position
      p_term_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (bit_en && !frame_sync && frame_active && bit_pos >= RELAY_FROM)
          |=> (chain_out == 1'b0));
    end
  endgenerate

endmodule

// File: tb/tdm_cascade_node_tb.sv
module tdm_cascade_node_tb;

  localparam int unsigned DEPTH = 4;
  localparam int unsigned NBITS = 256;

  localparam logic [255:0] VEC [4] = '{
    256'h8001_7FFE_1234_5678_9ABC_DEF0_0F0F_F0F0_AAAA_5555_C3C3_3C3C_0001_8000_FFFF_0000,
    256'h1111_2222_3333_4444_5555_6666_7777_8888_9999_AAAA_BBBB_CCCC_DDDD_EEEE_FFFF_0101,
    256'h0000_0000_0000_0000_FFFF_FFFF_FFFF_FFFF_0000_0000_0000_0000_FFFF_FFFF_FFFF_FFFF,
    256'hDEAD_BEEF_CAFE_F00D_0BAD_D00D_FACE_B00C_1357_9BDF_2468_ACE0_7E7E_8181_6996_9669
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bit_en = 1'b0;
  logic        frame_sync = 1'b0;
  logic [63:0] loc [4];
  logic        s0, s1, s2, s3;
  logic        far_in = 1'b1;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  tdm_cascade_node #(.CHAIN_DEPTH(DEPTH), .NODE_INDEX(0)) u_dut (
    .clk(clk), .rst(rst), .bit_en(bit_en), .frame_sync(frame_sync),
    .local_samples(loc[0]), .chain_in(s1), .chain_out(s0));
  tdm_cascade_node #(.CHAIN_DEPTH(DEPTH), .NODE_INDEX(1)) u_node1 (
    .clk(clk), .rst(rst), .bit_en(bit_en), .frame_sync(frame_sync),
    .local_samples(loc[1]), .chain_in(s2), .chain_out(s1));
  tdm_cascade_node #(.CHAIN_DEPTH(DEPTH), .NODE_INDEX(2)) u_node2 (
    .clk(clk), .rst(rst), .bit_en(bit_en), .frame_sync(frame_sync),
    .local_samples(loc[2]), .chain_in(s3), .chain_out(s2));
  tdm_cascade_node #(.CHAIN_DEPTH(DEPTH), .NODE_INDEX(3)) u_node3 (
    .clk(clk), .rst(rst), .bit_en(bit_en), .frame_sync(frame_sync),
    .local_samples(loc[3]), .chain_in(far_in), .chain_out(s3));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input logic fs);
    @(negedge clk);
    bit_en = 1'b1;
    frame_sync = fs;
    @(negedge clk);
    bit_en = 1'b0;
    frame_sync = 1'b0;
  endtask

  task automatic load(input logic [255:0] v);
    for (int i = 0; i < 4; i++) loc[i] = v[255-64*i -: 64];
  endtask

  // Runs one whole frame and captures stage 0 and stage 3 streams.
  task automatic run_frame(input logic [255:0] v, input logic scramble,
                           output logic [255:0] cap0, output logic [255:0] cap3);
    load(v);
    tick(1'b1);
    cap0[255] = s0;
    cap3[255] = s3;
    if (scramble) load(~v);
    for (int p = 1; p < NBITS; p++) begin
      tick(1'b0);
      cap0[255-p] = s0;
      cap3[255-p] = s3;
    end
  endtask

  task automatic check_frame(input logic [255:0] v, input logic [255:0] cap0,
                             input logic [255:0] cap3);
    for (int s = 0; s < 16; s++) begin
      if (s < 4) chk("R1 R2 stage0 own slot", 64'(cap0[255-16*s -: 16]), 64'(v[255-16*s -: 16]));
      else       chk("R3 R4 relayed slot", 64'(cap0[255-16*s -: 16]), 64'(v[255-16*s -: 16]));
    end
    chk("R5 farthest own group", cap3[255:192], v[63:0]);
    chk("R5 farthest relay zero", 64'(cap3[191:0] != '0), 64'd0);
  endtask

  initial begin
    #800000;
    failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
    $finish;
  end

  initial begin
    logic [255:0] c0, c3;
    logic         held;
    logic         any;
    load(256'h0);
    repeat (4) @(negedge clk);
    chk("R9 output low in reset", 64'(s0), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 output low after reset", 64'({s0, s1, s2, s3}), 64'd0);

    // R6: bit enables before any frame sync keep the line low
    load(~256'h0);
    any = 1'b0;
    for (int k = 0; k < 5; k++) begin
      tick(1'b0);
      any = any | s0 | s3;
    end
    chk("R6 idle before first frame", 64'(any), 64'd0);

    // Table walk: back-to-back frames, odd entries scrambled after sync (R2)
    for (int f = 0; f < 4; f++) begin
      run_frame(VEC[f], f[0], c0, c3);
      check_frame(VEC[f], c0, c3);
    end

    // R6: past the end of a frame the line stays low
    any = 1'b0;
    for (int k = 0; k < 8; k++) begin
      tick(1'b0);
      any = any | s0;
    end
    chk("R6 low after frame end", 64'(any), 64'd0);

    // R8: restart part-way through a frame
    load(VEC[2]);
    tick(1'b1);
    for (int k = 0; k < 29; k++) tick(1'b0);
    run_frame(VEC[1], 1'b1, c0, c3);
    chk("R8 restart own group", c0[255:192], VEC[1][255:192]);
    chk("R8 restart relayed groups", c0[191:128], VEC[1][191:128]);
    chk("R8 restart tail group", c0[63:0], VEC[1][63:0]);

    // R7: line holds between enables, sync without enable is ignored
    load(256'h0);
    loc[0] = 64'hFFFF_0000_0000_0000;
    tick(1'b1);
    held = s0;
    chk("R7 first bit set", 64'(held), 64'd1);
    repeat (3) @(negedge clk);
    frame_sync = 1'b1;
    @(negedge clk);
    frame_sync = 1'b0;
    repeat (2) @(negedge clk);
    chk("R7 hold without enable", 64'(s0), 64'(held));
    tick(1'b0);
    chk("R7 sync without enable ignored", 64'(s0), 64'd1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule